// File: doc/BRIEF.md
# Binary-template target match scorer

The block grades one region of 8-bit image pixels against a pair of 1-bit masks at a single search offset. One mask marks where a strong return is expected (bright). The other marks where shadow is expected (surround). Each offset takes two passes over the same serial stream, one mask position per beat. The first pass adds up the pixels under the bright mask and derives a threshold from their mean minus a bias. The second pass counts pixels below that threshold under each mask. After the second pass the block forms an integer percentage score and tests it against a minimum. Passing hits compete for the two best slots of the running match task.

A match task begins with a start pulse. The pulse clears both slots and latches the chip identifier. Each offset then streams 2×NPOS beats over a valid/ready handshake. The template identifier, row, column and last-offset flag are taken from the first accepted beat of the offset. After the last offset of a task the block raises a one-cycle done pulse.

Top module: `tmatch_scorer`

## Requirements
- R1: After reset, s_ready_o is 1, hit0_valid_o and hit1_valid_o are 0 and done_o is 0.
- R2: An offset is exactly 2×NPOS accepted beats (s_valid_i and s_ready_o both high at a rising edge). Beats 0..NPOS-1 form pass one and beats NPOS..2×NPOS-1 form pass two, in the same position order. In the cycle after the final beat, s_ready_o is 0 for exactly one cycle.
- R3: SM is the sum of the pixels whose bright bit is set in pass one, and BC is the count of set bright bits. The threshold is TH = floor(SM/BC) − bias_i, held at 0 when bias_i is not below the mean. Surround bits do not affect SM.
- R4: In pass two, BS counts positions with the bright bit set and pixel < TH. SS counts positions with the surround bit set and pixel < TH. SC is the count of set surround bits in pass one. The score is floor(100×(BS+SS)/(BC+SC)).
- R5: An offset is a hit only if its score is ≥ min_q_i.
- R6: If BC is 0, the offset is never a hit, even with min_q_i = 0.
- R7: The two hit slots hold the two highest scores in the task, with slot 0 ≥ slot 1. A new hit displaces an entry only if its score is strictly greater, so on a tie the earlier hit keeps the higher rank.
- R8: A hit's identifier is {chip_id_i at the task start, tmpl_id_i, pos_row_i, pos_col_i}, with chip in the most significant bits. The last three fields are sampled on the first accepted beat of the offset.
- R9: A high task_start_i clears both slots, and they read invalid in the next cycle.
- R10: done_o is high for one cycle, the cycle after the ready-low cycle of an offset whose first beat carried last_i = 1. The slots already show that offset's result in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| task_start_i | input | 1 | starts a match task and clears the slots |
| chip_id_i | input | CHIP_W | chip identifier, latched on task_start_i |
| bias_i | input | PIX_W | value subtracted from the bright mean |
| min_q_i | input | 7 | minimum score for a hit |
| s_valid_i | input | 1 | beat valid |
| s_ready_o | output | 1 | beat accepted when high |
| pix_i | input | PIX_W | image pixel |
| bright_i | input | 1 | bright mask bit |
| surround_i | input | 1 | surround mask bit |
| tmpl_id_i | input | TMPL_W | template identifier, first beat |
| pos_row_i | input | LOC_W | offset row, first beat |
| pos_col_i | input | LOC_W | offset column, first beat |
| last_i | input | 1 | last offset of the task, first beat |
| hit0_valid_o | output | 1 | best slot occupied |
| hit0_q_o | output | 7 | best score |
| hit0_id_o | output | ID_W | best identifier |
| hit1_valid_o | output | 1 | second slot occupied |
| hit1_q_o | output | 7 | second score |
| hit1_id_o | output | ID_W | second identifier |
| done_o | output | 1 | task finished pulse |

## Verification
A wrong accumulator or threshold shows up as a wrong score in a slot one cycle after the ready-low cycle of that offset. The offsets are random, so almost every offset exposes such a fault. A slip in the beat counter shifts the ready-low cycle, and the next offset's checks catch it at once. Faults in ranking, tie handling or clearing stay hidden until a second or third hit arrives. The directed tie, zero-bright and saturating-bias offsets are there to expose them on the offset that exercises them.

// File: rtl/tms_pkg.sv
package tms_pkg;
  localparam int unsigned Q_W = 7;
  localparam int unsigned PCT = 100;
  typedef enum logic [1:0] {ST_P1 = 2'd0, ST_P2 = 2'd1, ST_SCORE = 2'd2} tms_state_e;
endpackage

// File: rtl/tms_accum.sv
module tms_accum #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned CNT_W = 5,
  localparam int unsigned SM_W = PIX_W + CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             p1_en_i,
  input  logic             p2_en_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             bright_i,
  input  logic             surround_i,
  input  logic [PIX_W-1:0] th_i,
  output logic [SM_W-1:0]  sm_o,
  output logic [CNT_W-1:0] bc_o,
  output logic [CNT_W-1:0] sc_o,
  output logic [CNT_W-1:0] bs_o,
  output logic [CNT_W-1:0] ss_o
);
  logic below;
  assign below = pix_i < th_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sm_o <= '0; bc_o <= '0; sc_o <= '0; bs_o <= '0; ss_o <= '0;
    end else if (clr_i) begin
      sm_o <= '0; bc_o <= '0; sc_o <= '0; bs_o <= '0; ss_o <= '0;
    end else if (p1_en_i) begin
      if (bright_i) begin
        sm_o <= sm_o + SM_W'(pix_i);
        bc_o <= bc_o + 1'b1;
      end
      if (surround_i) sc_o <= sc_o + 1'b1;
    end else if (p2_en_i) begin
      if (bright_i && below)   bs_o <= bs_o + 1'b1;
      if (surround_i && below) ss_o <= ss_o + 1'b1;
    end
  end
endmodule

// File: rtl/tms_score.sv
module tms_score #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned CNT_W = 5,
  localparam int unsigned SM_W  = PIX_W + CNT_W,
  localparam int unsigned Q_W   = tms_pkg::Q_W,
  localparam int unsigned NUM_W = CNT_W + 1 + Q_W
) (
  input  logic [SM_W-1:0]  sm_i,
  input  logic [CNT_W-1:0] bc_i,
  input  logic [CNT_W-1:0] sc_i,
  input  logic [CNT_W-1:0] bs_i,
  input  logic [CNT_W-1:0] ss_i,
  input  logic [PIX_W-1:0] bias_i,
  input  logic [Q_W-1:0]   min_q_i,
  output logic [PIX_W-1:0] th_o,
  output logic [Q_W-1:0]   q_o,
  output logic             hit_o
);
  logic [SM_W-1:0]  mean;
  logic [NUM_W-1:0] num, den, quo;

  always_comb begin
    mean = (bc_i == '0) ? '0 : sm_i / SM_W'(bc_i);
    th_o = (mean > SM_W'(bias_i)) ? PIX_W'(mean - SM_W'(bias_i)) : '0;
    num  = (NUM_W'(bs_i) + NUM_W'(ss_i)) * NUM_W'(tms_pkg::PCT);
    den  = NUM_W'(bc_i) + NUM_W'(sc_i);
    quo  = (den == '0) ? '0 : num / den;
    q_o  = Q_W'(quo);
    hit_o = (bc_i != '0) && (q_o >= min_q_i);
  end
endmodule

// File: rtl/tms_rank.sv
module tms_rank #(
  parameter int unsigned ID_W = 16,
  localparam int unsigned Q_W = tms_pkg::Q_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            upd_i,
  input  logic [Q_W-1:0]  q_i,
  input  logic [ID_W-1:0] id_i,
  output logic            h0_valid_o,
  output logic [Q_W-1:0]  h0_q_o,
  output logic [ID_W-1:0] h0_id_o,
  output logic            h1_valid_o,
  output logic [Q_W-1:0]  h1_q_o,
  output logic [ID_W-1:0] h1_id_o
);
  logic beat0, beat1;
  assign beat0 = !h0_valid_o || (q_i > h0_q_o);
  assign beat1 = !h1_valid_o || (q_i > h1_q_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h0_valid_o <= 1'b0; h0_q_o <= '0; h0_id_o <= '0;
      h1_valid_o <= 1'b0; h1_q_o <= '0; h1_id_o <= '0;
    end else if (clr_i) begin
      h0_valid_o <= 1'b0; h1_valid_o <= 1'b0;
    end else if (upd_i) begin
      if (beat0) begin
        h1_valid_o <= h0_valid_o; h1_q_o <= h0_q_o; h1_id_o <= h0_id_o;
        h0_valid_o <= 1'b1;       h0_q_o <= q_i;    h0_id_o <= id_i;
      end else if (beat1) begin
        h1_valid_o <= 1'b1;       h1_q_o <= q_i;    h1_id_o <= id_i;
      end
    end
  end
endmodule

// File: rtl/tmatch_scorer.sv
module tmatch_scorer #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned NPOS   = 16,
  parameter int unsigned CHIP_W = 4,
  parameter int unsigned TMPL_W = 4,
  parameter int unsigned LOC_W  = 4,
  localparam int unsigned ID_W  = CHIP_W + TMPL_W + 2 * LOC_W,
  localparam int unsigned CNT_W = $clog2(NPOS + 1),
  localparam int unsigned IDX_W = (NPOS > 1) ? $clog2(NPOS) : 1,
  localparam int unsigned SM_W  = PIX_W + CNT_W,
  localparam int unsigned Q_W   = tms_pkg::Q_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              task_start_i,
  input  logic [CHIP_W-1:0] chip_id_i,
  input  logic [PIX_W-1:0]  bias_i,
  input  logic [Q_W-1:0]    min_q_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              bright_i,
  input  logic              surround_i,
  input  logic [TMPL_W-1:0] tmpl_id_i,
  input  logic [LOC_W-1:0]  pos_row_i,
  input  logic [LOC_W-1:0]  pos_col_i,
  input  logic              last_i,
  output logic              hit0_valid_o,
  output logic [Q_W-1:0]    hit0_q_o,
  output logic [ID_W-1:0]   hit0_id_o,
  output logic              hit1_valid_o,
  output logic [Q_W-1:0]    hit1_q_o,
  output logic [ID_W-1:0]   hit1_id_o,
  output logic              done_o
);
  import tms_pkg::*;

  tms_state_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CHIP_W-1:0] chip_q;
  logic [ID_W-CHIP_W-1:0] tag_q;
  logic last_q;
  logic acc, end_pass;
  logic [SM_W-1:0] sm;
  logic [CNT_W-1:0] bc, sc, bs, ss;
  logic [PIX_W-1:0] th;
  logic [Q_W-1:0] q;
  logic hit;

  assign s_ready_o = (state_q != ST_SCORE);
  assign acc       = s_valid_i && s_ready_o;
  assign end_pass  = acc && (idx_q == IDX_W'(NPOS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_P1;
      idx_q   <= '0;
      chip_q  <= '0;
      tag_q   <= '0;
      last_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= (state_q == ST_SCORE) && last_q;
      if (task_start_i) chip_q <= chip_id_i;
      if (acc && state_q == ST_P1 && idx_q == '0) begin
        tag_q  <= {tmpl_id_i, pos_row_i, pos_col_i};
        last_q <= last_i;
      end
      if (acc) idx_q <= end_pass ? '0 : idx_q + 1'b1;
      unique case (state_q)
        ST_P1:    if (end_pass) state_q <= ST_P2;
        ST_P2:    if (end_pass) state_q <= ST_SCORE;
        default:  state_q <= ST_P1;
      endcase
    end
  end

  tms_accum #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_accum (
    .clk_i, .rst_ni,
    .clr_i     (state_q == ST_SCORE),
    .p1_en_i   (acc && state_q == ST_P1),
    .p2_en_i   (acc && state_q == ST_P2),
    .pix_i, .bright_i, .surround_i,
    .th_i      (th),
    .sm_o (sm), .bc_o (bc), .sc_o (sc), .bs_o (bs), .ss_o (ss)
  );

  tms_score #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_score (
    .sm_i (sm), .bc_i (bc), .sc_i (sc), .bs_i (bs), .ss_i (ss),
    .bias_i, .min_q_i,
    .th_o (th), .q_o (q), .hit_o (hit)
  );

  tms_rank #(.ID_W(ID_W)) u_rank (
    .clk_i, .rst_ni,
    .clr_i      (task_start_i),
    .upd_i      (state_q == ST_SCORE && hit),
    .q_i        (q),
    .id_i       ({chip_q, tag_q}),
    .h0_valid_o (hit0_valid_o), .h0_q_o (hit0_q_o), .h0_id_o (hit0_id_o),
    .h1_valid_o (hit1_valid_o), .h1_q_o (hit1_q_o), .h1_id_o (hit1_id_o)
  );
endmodule

// File: rtl/tmatch_scorer_chk.sv
module tmatch_scorer_chk #(
  parameter int unsigned ID_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            task_start_i,
  input logic            s_ready_o,
  input logic            hit0_valid_o,
  input logic [6:0]      hit0_q_o,
  input logic            hit1_valid_o,
  input logic [6:0]      hit1_q_o,
  input logic            done_o
);
  assert_ready_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_ready_o |=> s_ready_o);
  assert_rank_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit0_valid_o && hit1_valid_o) |-> (hit0_q_o >= hit1_q_o));
  assert_slot_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit1_valid_o |-> hit0_valid_o);
  assert_pct_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit0_valid_o |-> (hit0_q_o <= 7'd100));
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_start_i |=> (!hit0_valid_o && !hit1_valid_o));
  assert_done_after_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!s_ready_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind tmatch_scorer tmatch_scorer_chk #(.ID_W(ID_W)) u_chk (
  .clk_i, .rst_ni, .task_start_i, .s_ready_o,
  .hit0_valid_o, .hit0_q_o, .hit1_valid_o, .hit1_q_o, .done_o
);

// File: tb/sim_tmatch_scorer.sv
`timescale 1ns/1ps
module sim_tmatch_scorer;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic task_start = 1'b0;
  logic [3:0] chip_id = '0;
  logic [7:0] bias = '0;
  logic [6:0] min_q = '0;
  logic s_valid = 1'b0, s_ready;
  logic [7:0] pix = '0;
  logic bright = 1'b0, surround = 1'b0;
  logic [3:0] tmpl_id = '0, pos_row = '0, pos_col = '0;
  logic last = 1'b0;
  logic h0v, h1v, done;
  logic [6:0] h0q, h1q;
  logic [15:0] h0id, h1id;

  int checks = 0, errors = 0;
  int px [N];
  bit br [N], sr [N];
  int e0v, e0q, e0id, e1v, e1q, e1id;
  logic [3:0] cur_chip;

  always #2.5 clk = ~clk;

  tmatch_scorer u0 (
    .clk_i(clk), .rst_ni(rst_n), .task_start_i(task_start), .chip_id_i(chip_id),
    .bias_i(bias), .min_q_i(min_q), .s_valid_i(s_valid), .s_ready_o(s_ready),
    .pix_i(pix), .bright_i(bright), .surround_i(surround), .tmpl_id_i(tmpl_id),
    .pos_row_i(pos_row), .pos_col_i(pos_col), .last_i(last),
    .hit0_valid_o(h0v), .hit0_q_o(h0q), .hit0_id_o(h0id),
    .hit1_valid_o(h1v), .hit1_q_o(h1q), .hit1_id_o(h1id), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference score from the requirements (R3, R4, R5, R6)
  function automatic void model(input int b, input int mq, output int q, output int v);
    int sm = 0, bc = 0, sc = 0, bs = 0, ss = 0, mean, th;
    for (int k = 0; k < N; k++) begin
      if (br[k]) begin sm += px[k]; bc++; end
      if (sr[k]) sc++;
    end
    mean = (bc == 0) ? 0 : sm / bc;
    th = (mean > b) ? mean - b : 0;
    for (int k = 0; k < N; k++) begin
      if (br[k] && px[k] < th) bs++;
      if (sr[k] && px[k] < th) ss++;
    end
    q = (bc + sc == 0) ? 0 : ((bs + ss) * 100) / (bc + sc);
    v = (bc != 0 && q >= mq) ? 1 : 0;
  endfunction

  task automatic start_task(input logic [3:0] c);
    @(negedge clk);
    task_start = 1'b1; chip_id = c;
    @(negedge clk);
    task_start = 1'b0; chip_id = ~c;
    cur_chip = c;
    e0v = 0; e1v = 0;
    chk("R9 clear slot0", h0v, 0);
    chk("R9 clear slot1", h1v, 0);
  endtask

  task automatic fill(input int mode);
    for (int k = 0; k < N; k++) begin
      case (mode)
        1: begin px[k] = $urandom_range(255); br[k] = 0; sr[k] = $urandom_range(1); end
        2: begin px[k] = 200; br[k] = 1; sr[k] = 0; end
        default: begin
          px[k] = $urandom_range(255);
          br[k] = ($urandom_range(2) == 0);
          sr[k] = !br[k] && ($urandom_range(1) == 1);
        end
      endcase
    end
  endtask

  task automatic run_offset(input int t, input int r, input int c, input bit lst);
    int q, v, id;
    model(int'(bias), int'(min_q), q, v);
    id = {cur_chip, t[3:0], r[3:0], c[3:0]};
    for (int k = 0; k < 2 * N; k++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) begin
        s_valid = 1'b0; pix = 8'hAA;
        @(negedge clk);
      end
      s_valid = 1'b1;
      pix = px[k % N][7:0]; bright = br[k % N]; surround = sr[k % N];
      tmpl_id = (k == 0) ? t[3:0] : ~t[3:0];
      pos_row = (k == 0) ? r[3:0] : ~r[3:0];
      pos_col = (k == 0) ? c[3:0] : ~c[3:0];
      last    = (k == 0) ? lst : !lst;
      @(posedge clk);
    end
    @(negedge clk);
    chk("R2 ready low after final beat", s_ready, 0);
    chk("R10 no done in gap", done, 0);
    s_valid = 1'b0;
    if (v != 0) begin
      if (e0v == 0 || q > e0q) begin
        e1v = e0v; e1q = e0q; e1id = e0id;
        e0v = 1; e0q = q; e0id = id;
      end else if (e1v == 0 || q > e1q) begin
        e1v = 1; e1q = q; e1id = id;
      end
    end
    @(negedge clk);
    chk("R2 ready back", s_ready, 1);
    chk("R10 done", done, int'(lst));
    chk("R5 slot0 valid", h0v, e0v);
    if (e0v != 0) begin
      chk("R4 slot0 score", h0q, e0q);
      chk("R8 slot0 id", h0id, e0id);
    end
    chk("R7 slot1 valid", h1v, e1v);
    if (e1v != 0) begin
      chk("R7 slot1 score", h1q, e1q);
      chk("R8 slot1 id", h1id, e1id);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R1 ready", s_ready, 1);
    chk("R1 slot0", h0v, 0);
    chk("R1 slot1", h1v, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;

    // random offsets, low bias
    start_task(4'h3);
    bias = 8'd5; min_q = 7'd0;
    for (int o = 0; o < 6; o++) begin
      fill(0);
      run_offset(o, o + 1, 15 - o, o == 5);
    end

    // R6: no bright bits with min 0; R3: bias above mean saturates TH to 0
    start_task(4'h9);
    min_q = 7'd0; bias = 8'd0;
    fill(1); run_offset(1, 2, 3, 0);
    chk("R6 zero bright no hit", h0v, 0);
    bias = 8'd255;
    fill(0); run_offset(2, 3, 4, 0);
    chk("R3 saturated threshold score 0", h0q, 0);
    // uniform bright pixels equal to mean: nothing below TH at bias 0
    bias = 8'd0; fill(2); run_offset(3, 4, 5, 1);

    // R7: ties keep earlier rank
    start_task(4'hC);
    bias = 8'd20; min_q = 7'd0;
    fill(0);
    run_offset(7, 1, 1, 0);
    run_offset(8, 2, 2, 0);
    chk("R7 tie earlier first", h0id, {4'hC, 4'd7, 4'd1, 4'd1});
    run_offset(9, 3, 3, 1);

    // R5: high minimum filters, random bias
    for (int tk = 0; tk < 4; tk++) begin
      start_task(tk[3:0]);
      min_q = 7'($urandom_range(60));
      for (int o = 0; o < 8; o++) begin
        bias = 8'($urandom_range(40));
        fill(0);
        run_offset(o, tk, o, o == 7);
      end
    end
    min_q = 7'd100; start_task(4'h1);
    fill(0); run_offset(1, 1, 1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule